// File: doc/BRIEF.md
# JTAG configuration access controller

This block is the test access port of a programmable device that also loads itself through an active configuration engine. It runs the standard sixteen-state TAP machine from the test clock, mode and data pins and an optional asynchronous reset. It offers a one-bit bypass path, a 32-bit identification register, a pin sample register, a configuration status register and a serial configuration data path. Boundary cells and configuration memory are not part of the block. They appear only as a pin vector input and a bit strobe output.

While the active engine is loading (`cfg_active` high), the decoder lets only identification, bypass, pin sampling and the two engage controls through. Any other instruction is replaced by bypass until configuration has been interrupted. To interrupt it, first hold the active engine idle with the disengage instruction, then issue the I/O takeover instruction. The engage instruction releases the engine. After the last bit of a serial bitstream, the block counts a fixed run of initialization clocks and then raises the done flag. Software can read that flag back through the status register.

Top module: `jtag_cfg_access`

## Requirements
- R1: An asynchronous low `trst_n`, or five TCK rising edges with `tms` high, puts the TAP in Test-Logic-Reset. That state selects the identification register, and a DR scan then returns `IDCODE_VAL` (default 32'h1A2B_C0DF, bit 0 = 1), LSB first.
- R2: Capture-IR loads the 10-bit instruction shift register with 1 in bit 0 and 0 in all other bits. `tdo_oe` is high only while shifting IR or DR.
- R3: Opcode 10'h3FF, and any opcode not listed here, selects the one-bit bypass register: a bit on `tdi` shows on `tdo` one TCK cycle later, and the first bit out is 0.
- R4: With `cfg_active` high, identification (10'h006), bypass and sample (10'h005) still operate. Sample captures `pins_in` in Capture-DR and shifts it out LSB first, and `act_hold` stays low.
- R5: With `cfg_active` high and configuration not interrupted, program (10'h002), status (10'h004) and an I/O takeover (10'h00D) not preceded by disengage all act as bypass. `cfg_bit_vld`, `io_ctl` and `cfg_interrupt` stay low.
- R6: Disengage (10'h2D0) sets `act_hold` at Update-IR. It stays set across later instructions until engage or `trst_n`.
- R7: I/O takeover raises `io_ctl` while it is the current instruction. If `act_hold` is set, it also sets `cfg_interrupt`, after which every instruction is allowed.
- R8: Engage (10'h2B0) clears `act_hold` and `cfg_interrupt` at Update-IR, and `io_ctl` drops.
- R9: Under the program instruction, every Shift-DR clock asserts `cfg_bit_vld` with `cfg_bit` equal to `tdi`. The path to `tdo` is one bit long.
- R10: `conf_done` rises on exactly the 3180th TCK rising edge after the edge that shifts the last program bit (the one with `tms` high). Any new program bit clears it.
- R11: The status register captures `act_hold` in bit 1 and `conf_done` in bit 0.
- R12: `tdo` and `tdo_oe` change only on the falling edge of TCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid when `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for `tdo` |
| cfg_active | input | 1 | Active configuration engine is loading |
| pins_in | input | NPIN | Pin levels seen by the sample register |
| act_hold | output | 1 | Hold the active configuration engine idle |
| io_ctl | output | 1 | I/O configuration is under JTAG control |
| cfg_interrupt | output | 1 | Active configuration has been interrupted |
| cfg_bit_vld | output | 1 | Strobe: a configuration bit is on `cfg_bit` this cycle |
| cfg_bit | output | 1 | Configuration data bit |
| conf_done | output | 1 | Initialization after the JTAG bitstream is complete |

## Verification
The bypass path is swept with all 256 eight-bit patterns, plus one unlisted opcode. This catches a missing delay, an extra delay, or a bit-order swap. Sample is tried with several pin vectors, which separates real capture from a stuck or shifted register. The gating rules are exercised as an ordered sequence: gated program, takeover without disengage, disengage, takeover, program, engage. Each step is checked against the sideband outputs and the strobe count, which separates a missing gate from a gate that never opens. The done count is probed one edge before and at the 3180th edge to catch off-by-one errors.

// File: rtl/jtag_cfg_access.sv
module jtag_cfg_access #(
  parameter int              IR_W        = 10,
  parameter int              ID_W        = 32,
  parameter int              NPIN        = 8,
  parameter int              INIT_CYCLES = 3180,
  parameter logic [ID_W-1:0] IDCODE_VAL  = 32'h1A2B_C0DF,
  parameter logic [IR_W-1:0] OP_BYPASS   = 10'h3FF,
  parameter logic [IR_W-1:0] OP_IDCODE   = 10'h006,
  parameter logic [IR_W-1:0] OP_SAMPLE   = 10'h005,
  parameter logic [IR_W-1:0] OP_PROGRAM  = 10'h002,
  parameter logic [IR_W-1:0] OP_STATUS   = 10'h004,
  parameter logic [IR_W-1:0] OP_IOCTL    = 10'h00D,
  parameter logic [IR_W-1:0] OP_DISENG   = 10'h2D0,
  parameter logic [IR_W-1:0] OP_ENGAGE   = 10'h2B0
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic            cfg_active,
  input  logic [NPIN-1:0] pins_in,
  output logic            act_hold,
  output logic            io_ctl,
  output logic            cfg_interrupt,
  output logic            cfg_bit_vld,
  output logic            cfg_bit,
  output logic            conf_done
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PSDR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PSIR, S_EX2IR, S_UPIR
  } tap_t;

  typedef enum logic [2:0] {
    I_BYP, I_ID, I_SAMP, I_PROG, I_STAT, I_IOC, I_DIS, I_ENG
  } ins_t;

  tap_t state, nstate;
  ins_t ins, dec, ins_nxt;
  logic [IR_W-1:0] ir_sh;
  logic [ID_W-1:0] id_sh;
  logic [NPIN-1:0] samp_sh;
  logic [1:0]      stat_sh;
  logic            byp_r, dr_out, busy, free;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (state)
      S_TLR:   nstate = tms ? S_TLR   : S_RTI;
      S_RTI:   nstate = tms ? S_SELDR : S_RTI;
      S_SELDR: nstate = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nstate = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nstate = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nstate = tms ? S_UPDR  : S_PSDR;
      S_PSDR:  nstate = tms ? S_EX2DR : S_PSDR;
      S_EX2DR: nstate = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  nstate = tms ? S_SELDR : S_RTI;
      S_SELIR: nstate = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nstate = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nstate = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nstate = tms ? S_UPIR  : S_PSIR;
      S_PSIR:  nstate = tms ? S_EX2IR : S_PSIR;
      S_EX2IR: nstate = tms ? S_UPIR  : S_SHIR;
      default: nstate = tms ? S_SELDR : S_RTI;
    endcase
  end

  always_comb begin
    if      (ir_sh == OP_IDCODE)  dec = I_ID;
    else if (ir_sh == OP_SAMPLE)  dec = I_SAMP;
    else if (ir_sh == OP_PROGRAM) dec = I_PROG;
    else if (ir_sh == OP_STATUS)  dec = I_STAT;
    else if (ir_sh == OP_IOCTL)   dec = I_IOC;
    else if (ir_sh == OP_DISENG)  dec = I_DIS;
    else if (ir_sh == OP_ENGAGE)  dec = I_ENG;
    else                          dec = I_BYP;
    free    = (dec inside {I_BYP, I_ID, I_SAMP, I_DIS, I_ENG}) || (dec == I_IOC && act_hold);
    ins_nxt = (cfg_active && !cfg_interrupt && !free) ? I_BYP : dec;
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= nstate;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ins <= I_ID;
      ir_sh <= '0;
      act_hold <= 1'b0;
      cfg_interrupt <= 1'b0;
    end else begin
      case (state)
        S_TLR:   ins <= I_ID;
        S_CAPIR: ir_sh <= IR_W'(1);
        S_SHIR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        S_UPIR: begin
          ins <= ins_nxt;
          if (ins_nxt == I_DIS) act_hold <= 1'b1;
          if (ins_nxt == I_IOC && act_hold) cfg_interrupt <= 1'b1;
          if (ins_nxt == I_ENG) begin
            act_hold <= 1'b0;
            cfg_interrupt <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_r <= 1'b0;
      id_sh <= '0;
      samp_sh <= '0;
      stat_sh <= '0;
    end else if (state == S_CAPDR) begin
      case (ins)
        I_ID:    id_sh <= IDCODE_VAL;
        I_SAMP:  samp_sh <= pins_in;
        I_STAT:  stat_sh <= {act_hold, conf_done};
        default: byp_r <= 1'b0;
      endcase
    end else if (state == S_SHDR) begin
      case (ins)
        I_ID:    id_sh <= {tdi, id_sh[ID_W-1:1]};
        I_SAMP:  samp_sh <= {tdi, samp_sh[NPIN-1:1]};
        I_STAT:  stat_sh <= {tdi, stat_sh[1]};
        default: byp_r <= tdi;
      endcase
    end
  end

  always_comb
    case (ins)
      I_ID:    dr_out = id_sh[0];
      I_SAMP:  dr_out = samp_sh[0];
      I_STAT:  dr_out = stat_sh[0];
      default: dr_out = byp_r;
    endcase

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo <= (state == S_SHIR) ? ir_sh[0] : dr_out;
      tdo_oe <= (state == S_SHIR) || (state == S_SHDR);
    end

  assign io_ctl      = (ins == I_IOC);
  assign cfg_bit_vld = (state == S_SHDR) && (ins == I_PROG);
  assign cfg_bit     = tdi;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      busy <= 1'b0;
      cnt <= '0;
      conf_done <= 1'b0;
    end else if (cfg_bit_vld) begin
      conf_done <= 1'b0;
      busy <= tms;
      cnt <= '0;
    end else if (busy) begin
      if (cnt == CNT_W'(INIT_CYCLES - 1)) begin
        busy <= 1'b0;
        conf_done <= 1'b1;
      end
      cnt <= cnt + 1'b1;
    end

  AST_TLR_AFTER_FIVE: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5)) |-> state == S_TLR); // R1
  AST_INS_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(ins) |-> $past(state == S_UPIR || state == S_TLR)); // R1
  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == S_SHIR || state == S_SHDR)); // R2
  AST_INTERRUPT_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    cfg_interrupt |-> act_hold); // R7
  AST_HOLD_RELEASE: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(act_hold) |-> $past(state == S_UPIR)); // R8
  AST_DONE_AFTER_COUNT: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(conf_done) |-> ($past(busy) && !busy)); // R10
endmodule

// File: tb/jtag_cfg_access_bench.sv
`timescale 1ns/100ps
module jtag_cfg_access_bench;
  localparam logic [31:0] IDV = 32'h1A2B_C0DF;
  localparam logic [9:0] OPB = 10'h3FF, OPI = 10'h006, OPS = 10'h005, OPP = 10'h002,
                         OPT = 10'h004, OPC = 10'h00D, OPD = 10'h2D0, OPE = 10'h2B0;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, cfg_active = 1'b0;
  logic [7:0] pins_in = '0;
  logic tdo, tdo_oe, act_hold, io_ctl, cfg_interrupt, cfg_bit_vld, cfg_bit, conf_done;
  int tests = 0, fails = 0, vld_cnt = 0;
  logic [63:0] vld_bits = '0;
  logic oe_s, post_tdo, oe_bad;

  always #2 tck = ~tck;

  jtag_cfg_access u_jtag_cfg_access (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .cfg_active(cfg_active), .pins_in(pins_in), .act_hold(act_hold), .io_ctl(io_ctl),
    .cfg_interrupt(cfg_interrupt), .cfg_bit_vld(cfg_bit_vld), .cfg_bit(cfg_bit),
    .conf_done(conf_done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck); #0.5;
    o = tdo; oe_s = tdo_oe;
    tms = m; tdi = d;
    #0.5;
    if (cfg_bit_vld) begin
      vld_cnt++;
      vld_bits = {cfg_bit, vld_bits[63:1]};
    end
    @(posedge tck); #0.5;
    post_tdo = tdo;
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0; oe_bad = 1'b0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
      if (!oe_s) oe_bad = 1'b1;
    end
    step(1, 0, o);
    if (oe_s) oe_bad = 1'b1;
    step(0, 0, o);
  endtask

  task automatic load_ir(input logic [9:0] code, output logic [9:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 10; i++) begin
      step(i == 9, code[i], o);
      cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(0, 0, o);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [9:0] cap;
    logic o;
    #9 trst_n = 1'b1;
    #1;
    chk("R1 reset outputs", {act_hold, io_ctl, cfg_interrupt, conf_done, tdo_oe}, '0);
    idle(1);
    shift_dr(32, 64'h0, d);
    chk("R1 idcode after trst", d[31:0], IDV);
    chk("R2 oe only in shift", oe_bad, 0);

    load_ir(OPB, cap);
    chk("R2 ir capture", cap, 10'h001);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    shift_dr(32, 64'h0, d);
    chk("R1 idcode after five tms", d[31:0], IDV);

    load_ir(OPB, cap);
    for (int p = 0; p < 256; p++) begin
      shift_dr(9, 64'(p), d);
      chk("R3 bypass delay", {d[8:1], d[0]}, {8'(p), 1'b0});
    end
    load_ir(10'h155, cap);
    shift_dr(9, 64'hA5, d);
    chk("R3 unknown opcode", d[8:0], {8'hA5, 1'b0});

    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    step(0, 1, o); step(0, 0, o);
    chk("R12 tdo holds at rising edge", post_tdo, 1'b1);
    step(1, 0, o);
    chk("R12 tdo moves at falling edge", o, 1'b0);
    step(1, 0, o); step(0, 0, o);

    cfg_active = 1'b1;
    load_ir(OPS, cap);
    foreach (d[k]) if (k < 4) begin
      pins_in = 8'h3C ^ 8'(k * 37);
      shift_dr(8, 64'h0, d);
      chk("R4 sample during config", d[7:0], 8'h3C ^ 8'(k * 37));
    end
    load_ir(OPI, cap);
    shift_dr(32, 64'h0, d);
    chk("R4 idcode during config", {act_hold, d[31:0]}, {1'b0, IDV});

    vld_cnt = 0;
    load_ir(OPP, cap);
    shift_dr(9, 64'h5A, d);
    chk("R5 program gated", {vld_cnt[7:0], d[8:0]}, {8'd0, 8'h5A, 1'b0});
    load_ir(OPC, cap);
    chk("R5 ioctl gated", {io_ctl, cfg_interrupt}, 2'b00);

    load_ir(OPD, cap);
    chk("R6 disengage sets hold", act_hold, 1'b1);
    load_ir(OPI, cap);
    chk("R6 hold persists", act_hold, 1'b1);

    load_ir(OPC, cap);
    chk("R7 takeover", {io_ctl, cfg_interrupt}, 2'b11);

    vld_cnt = 0;
    load_ir(OPP, cap);
    chk("R7 io control leaves with instruction", io_ctl, 1'b0);
    shift_dr(16, 64'hC3A5, d);
    chk("R9 strobe count", vld_cnt, 16);
    chk("R9 strobe bits", vld_bits[63:48], 16'hC3A5);
    chk("R9 tdo delay", d[16:0], {16'hC3A5, 1'b0} & 17'h0FFFF);
    idle(3177);
    chk("R10 not done at 3179", conf_done, 1'b0);
    idle(1);
    chk("R10 done at 3180", conf_done, 1'b1);

    load_ir(OPT, cap);
    shift_dr(2, 64'h0, d);
    chk("R11 status held and done", d[1:0], 2'b11);

    load_ir(OPE, cap);
    chk("R8 engage", {act_hold, cfg_interrupt, io_ctl}, 3'b000);

    cfg_active = 1'b0;
    load_ir(OPT, cap);
    shift_dr(2, 64'h0, d);
    chk("R11 status released", d[1:0], 2'b01);

    load_ir(OPP, cap);
    shift_dr(4, 64'h9, d);
    chk("R10 new bits clear done", conf_done, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule